// File: doc/BRIEF.md
# Subcarrier-referenced clock phase corrector

This block turns a master clock running at six times the colour subcarrier into a system-clock enable at half that rate, and keeps the divided clock in step with the video lines. The subcarrier is not a whole multiple of the line rate, so the divided clock drifts by half a period against the line raster. The block removes this drift by holding the divide-by-two for one master cycle, timed from horizontal sync. For PAL standards it does this on every second line, and for NTSC on every line.

A vertical strobe arms a one-shot line-start strobe. That strobe restarts the delay-line addressing on the first horizontal sync of each field, and the same vertical strobe fixes the phase of the PAL line alternation. A registered indicator tells the delay-line logic whether the NTSC taps (1 and 2 lines) or the PAL taps (2 and 4 lines) apply. While the mode controller asserts stop, the divider and all sequencing are held in a known state.

Top module: `clkPhaseCorrector`

## Requirements
- R1: After reset, sysClkEn, lineStart and isNtsc are all low.
- R2: isNtsc is high one master cycle after stdSel equals 2'b10 (NTSC M). It is low for 2'b00 (PAL M), 2'b01 (PAL B/G/H/D/I, the default) and 2'b11 (PAL N).
- R3: With stop low and no horizontal sync, sysClkEn changes value on every master-clock edge.
- R4: With NTSC selected, every accepted hSync pulse holds sysClkEn at its value for one extra master cycle (a 180° shift of the system clock).
- R5: With a PAL standard selected, the first hSync after vSync applies no hold and the second one applies a hold. The pattern then alternates line by line.
- R6: vSync resets the PAL line alternation, so the first hSync after it applies no hold regardless of how many lines came before.
- R7: The first hSync after a vSync produces exactly one lineStart pulse. The pulse lasts one master cycle and falls in a cycle where sysClkEn is high. Later hSync pulses produce no lineStart until the next vSync.
- R8: While stop is high, sysClkEn and lineStart stay low, and hSync and vSync are ignored. In particular, a vSync during stop does not arm lineStart.
- R9: After stop falls, sysClkEn is high in the first cycle after the first edge with stop low. The PAL alternation restarts so that the first hSync applies no hold.
- R10: When hSync and vSync arrive in the same cycle, the hSync is ignored: no hold is applied and no lineStart is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, six times subcarrier |
| rstN | input | 1 | Active-low synchronous reset |
| hSync | input | 1 | One-cycle horizontal sync strobe |
| vSync | input | 1 | One-cycle vertical sync strobe |
| stdSel | input | 2 | Video standard select |
| stop | input | 1 | Freeze request from the mode controller |
| sysClkEn | output | 1 | System-clock enable, half the master rate |
| lineStart | output | 1 | Once-per-field delay-line restart strobe |
| isNtsc | output | 1 | High when the NTSC delay taps apply |

## Verification
The hold is checked by sampling sysClkEn on either side of each hSync edge. NTSC sequences show a hold on every line. PAL sequences show the no-hold/hold alternation, which separates a per-line correction from an every-other-line one. An odd number of PAL lines followed by a vSync shows whether the alternation really restarts at the field boundary. Stop sequences that include sync strobes separate a frozen controller from one that keeps counting lines underneath. The coincident hSync and vSync case checks which of the two strobes wins.

// File: rtl/clkPhasePkg.sv
package clkPhasePkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_NTSC = 2'b10;

  typedef struct packed {
    logic hold;   // freeze divider and start latch
    logic stall;  // skip one divider toggle
    logic fire;   // request a line-start strobe
  } ctrlStrobes_t;
endpackage

// File: rtl/phaseCtrl.sv
module phaseCtrl
  import clkPhasePkg::*;
#(
  parameter logic [SEL_W-1:0] NTSC_CODE = SEL_NTSC
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hSync,
  input  logic             vSync,
  input  logic [SEL_W-1:0] stdSel,
  input  logic             stop,
  output ctrlStrobes_t     strobes,
  output logic             isNtsc
);
  logic lineOdd;
  logic armed;
  logic hAccept;

  // horizontal sync counts only when running and not shadowed by vSync
  assign hAccept = hSync & ~vSync & ~stop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isNtsc <= 1'b0;
    end else begin
      isNtsc <= (stdSel == NTSC_CODE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stop) begin
      lineOdd <= 1'b0;
      armed   <= 1'b0;
    end else if (vSync) begin
      lineOdd <= 1'b0;
      armed   <= 1'b1;
    end else if (hSync) begin
      lineOdd <= ~lineOdd;
      armed   <= 1'b0;
    end
  end

  always_comb begin
    strobes.hold  = stop;
    strobes.stall = hAccept & (isNtsc | lineOdd);
    strobes.fire  = hAccept & armed;
  end

  // R8: nothing is armed while frozen
  assert_stop_disarm_R8: assert property (@(posedge clk) disable iff (!rstN)
    stop |=> !armed && !lineOdd);
  // R2: indicator follows the select code one cycle later
  assert_std_decode_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> isNtsc == ($past(stdSel) == NTSC_CODE));
endmodule

// File: rtl/phaseDatapath.sv
module phaseDatapath
  import clkPhasePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  output logic         sysClkEn,
  output logic         lineStart
);
  logic divPh;
  logic startReq;

  always_ff @(posedge clk) begin
    if (!rstN || strobes.hold) begin
      divPh <= 1'b0;
    end else if (!strobes.stall) begin
      divPh <= ~divPh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.hold) begin
      startReq <= 1'b0;
    end else if (strobes.fire) begin
      startReq <= 1'b1;
    end else if (divPh) begin
      startReq <= 1'b0;
    end
  end

  assign sysClkEn  = divPh;
  assign lineStart = startReq & divPh;

  // R7: line-start strobe is one master cycle wide
  assert_start_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> !lineStart);
  // R4: a stall request leaves the enable unchanged
  assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stall && !strobes.hold) |=> $stable(sysClkEn));
endmodule

// File: rtl/clkPhaseCorrector.sv
module clkPhaseCorrector
  import clkPhasePkg::*;
#(
  parameter logic [SEL_W-1:0] NTSC_CODE = SEL_NTSC
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hSync,
  input  logic             vSync,
  input  logic [SEL_W-1:0] stdSel,
  input  logic             stop,
  output logic             sysClkEn,
  output logic             lineStart,
  output logic             isNtsc
);
  ctrlStrobes_t strobes;

  phaseCtrl #(.NTSC_CODE(NTSC_CODE)) uCtrl (
    .clk(clk), .rstN(rstN), .hSync(hSync), .vSync(vSync),
    .stdSel(stdSel), .stop(stop), .strobes(strobes), .isNtsc(isNtsc)
  );

  phaseDatapath uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .sysClkEn(sysClkEn), .lineStart(lineStart)
  );

  // R3: free-running half-rate toggle without sync or stop
  assert_free_toggle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!stop && !hSync) |=> sysClkEn != $past(sysClkEn));
  // R8: frozen outputs while stop is high
  assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    stop |=> !sysClkEn && !lineStart);
  // R10: coincident vSync hides hSync from the divider
  assert_vsync_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!stop && vSync) |=> sysClkEn != $past(sysClkEn));
endmodule

// File: tb/tb_clkPhaseCorrector.sv
module tb_clkPhaseCorrector;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hSync = 1'b0;
  logic vSync = 1'b0;
  logic [1:0] stdSel = 2'b01;
  logic stop = 1'b0;
  logic sysClkEn, lineStart, isNtsc;
  int nChecks = 0;
  int nErrors = 0;

  clkPhaseCorrector dut (
    .clk(clk), .rstN(rstN), .hSync(hSync), .vSync(vSync), .stdSel(stdSel),
    .stop(stop), .sysClkEn(sysClkEn), .lineStart(lineStart), .isNtsc(isNtsc)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // advance one edge, leave inputs settled 1 ns after it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // one hSync pulse; returns 1 when sysClkEn held across its edge
  task automatic hPulse(output bit held);
    logic e0;
    e0 = sysClkEn;
    hSync = 1'b1;
    step();
    hSync = 1'b0;
    held = (sysClkEn == e0);
  endtask

  task automatic vPulse();
    vSync = 1'b1;
    step();
    vSync = 1'b0;
  endtask

  // count lineStart pulses over n cycles, checking alignment
  task automatic countStarts(input int n, output int cnt, output bit aligned);
    cnt = 0;
    aligned = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (lineStart) begin
        cnt++;
        if (!sysClkEn) aligned = 1'b0;
      end
      step();
    end
  endtask

  task automatic testReset();
    chk(sysClkEn == 0, "R1 sysClkEn", sysClkEn, 0);
    chk(lineStart == 0, "R1 lineStart", lineStart, 0);
    chk(isNtsc == 0, "R1 isNtsc", isNtsc, 0);
  endtask

  task automatic testDecode();
    logic [1:0] codes [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
    for (int i = 0; i < 4; i++) begin
      stdSel = codes[i];
      step();
      chk(isNtsc == (codes[i] == 2'b10), "R2 decode", isNtsc, codes[i] == 2'b10);
    end
    stdSel = 2'b01;
    step();
  endtask

  task automatic testToggle();
    for (int i = 0; i < 6; i++) begin
      logic p;
      p = sysClkEn;
      step();
      chk(sysClkEn != p, "R3 toggle", sysClkEn, !p);
    end
  endtask

  task automatic testNtsc();
    bit held;
    stdSel = 2'b10;
    idle(2);
    vPulse();
    idle(3);
    for (int i = 0; i < 4; i++) begin
      hPulse(held);
      chk(held, "R4 ntsc hold", held, 1);
      idle(5 + i);
    end
    stdSel = 2'b01;
    idle(2);
  endtask

  task automatic testPal();
    bit held;
    vPulse();
    idle(3);
    for (int i = 0; i < 6; i++) begin
      hPulse(held);
      chk(held == (i % 2 == 1), "R5 pal alternation", held, i % 2 == 1);
      idle(6);
    end
    // odd number of lines then a new field
    hPulse(held);
    idle(4);
    vPulse();
    idle(3);
    hPulse(held);
    chk(!held, "R6 field reset parity", held, 0);
    idle(4);
  endtask

  task automatic testLineStart();
    int cnt;
    bit al;
    bit held;
    vPulse();
    idle(2);
    hPulse(held);
    countStarts(8, cnt, al);
    chk(cnt == 1, "R7 one pulse", cnt, 1);
    chk(al, "R7 aligned with enable", al, 1);
    hPulse(held);
    countStarts(8, cnt, al);
    chk(cnt == 0, "R7 no second pulse", cnt, 0);
  endtask

  task automatic testStop();
    int cnt;
    bit al;
    bit held;
    bit ok;
    stop = 1'b1;
    step();
    ok = 1'b1;
    for (int i = 0; i < 5; i++) begin
      if (sysClkEn || lineStart) ok = 1'b0;
      if (i == 1) vSync = 1'b1;
      if (i == 2) begin vSync = 1'b0; hSync = 1'b1; end
      if (i == 3) hSync = 1'b0;
      step();
    end
    chk(ok, "R8 quiet while stopped", ok, 1);
    stop = 1'b0;
    step();
    chk(sysClkEn == 1, "R9 restart phase", sysClkEn, 1);
    idle(3);
    hPulse(held);
    chk(!held, "R9 first line no hold", held, 0);
    countStarts(8, cnt, al);
    chk(cnt == 0, "R8 vSync ignored in stop", cnt, 0);
    hPulse(held);
    chk(held, "R9 second line hold", held, 1);
    idle(3);
  endtask

  task automatic testCoincident();
    int cnt;
    bit al;
    logic e0;
    stdSel = 2'b10;
    idle(2);
    e0 = sysClkEn;
    vSync = 1'b1;
    hSync = 1'b1;
    step();
    vSync = 1'b0;
    hSync = 1'b0;
    chk(sysClkEn != e0, "R10 no hold", sysClkEn, !e0);
    countStarts(8, cnt, al);
    chk(cnt == 0, "R10 no lineStart", cnt, 0);
    stdSel = 2'b01;
    idle(2);
  endtask

  initial begin
    #200000;
    nErrors++;
    nChecks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    idle(3);
    testReset();
    rstN = 1'b1;
    step();
    testDecode();
    testToggle();
    testNtsc();
    testPal();
    testLineStart();
    testStop();
    testCoincident();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule